// File: doc/BRIEF.md
# JTAG Burst Memory Access Engine

This block sits behind a JTAG data-register shift path and lets a debug host read or write a run of memory words through a simple request/acknowledge bus-master port. A burst command is presented in parallel and gives three things: the access size in bytes (1, 2 or 4), a 16-bit word count and a start address. After that, every transfer happens one bit per shift cycle. `tdi` carries bits from the host and `tdo` returns bits to it.

A read burst returns a status bit ahead of each word. The host keeps shifting until that bit is 1, and then receives the word least significant bit first. After the last word, the engine returns the 32-bit CRC it built over the data bits. The fetch of the first word starts as soon as the command is taken, so on a fast bus the first status bit is often already ready.

A write burst takes the data words and then the host's 32-bit CRC. One more shift returns a bit that says whether the two CRCs agree. A bus error does not stop the burst: it marks a sticky error flag. Commands are refused while a burst or bus access is in progress. When a burst ends, the engine is idle straight away and does not need any padding bits.

Top module: `jtag_burst_engine`

## Requirements
- R1: A command is taken on a clock where `cmdValid` is high, `busy` is low, `cmdSize` is 1, 2 or 4 and `cmdCount` is not zero. Any other command is ignored, and that includes every command given while `busy` is high.
- R2: The CRC uses the reflected IEEE 802.3 polynomial 0xEDB88320. It is set to all ones when a command is taken and is updated once for each data bit, in shift order. The update is `c = (c >> 1) ^ ((c[0] ^ bit) ? 0xEDB88320 : 0)`. No final inversion is applied, and the CRC bits themselves are not included.
- R3: A read burst raises `memReq` on the clock after the command is taken, with no shifting needed. If the host polls only after the bus has answered, the first status bit is 1.
- R4: Each read word is preceded by status bits. A status shift returns 0 while the word is not yet available and does not move the burst forward. The first shift that returns 1 is followed by the word's data bits.
- R5: Each word is `cmdSize`×8 bits long and moves least significant bit first. The word sits right-aligned on `memRdata` and `memWdata`. `memAddr` starts at the command address and grows by `cmdSize` after each access completes.
- R6: After the data bits of the last read word, the next 32 shifts return the R2 CRC least significant bit first. The burst then ends.
- R7: In a write burst, the bits of each word are written as one bus access, with `memWe` high, which starts on the clock after that word's last bit.
- R8: After the last write word, 32 shifts take in the host CRC least significant bit first. The next shift returns 1 if it equals the R2 CRC and 0 if it does not. The burst then ends, and the data writes happen whatever the outcome.
- R9: After the final bit of a burst, the engine is idle without any extra shifts. A new command can be taken on the very next clock.
- R10: A cycle that ends with `memErr` still completes the access and the address step. A read word that ends this way is returned as zeros. `errFlag` goes high and stays high until reset.
- R11: `memReq` stays high, with a stable `memAddr` and `memWe`, until `memAck` or `memErr` arrives.
- R12: While `busy` is low, `tdo` is 0, and after reset `busy`, `memReq` and `errFlag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift and bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Burst command strobe |
| cmdWrite | input | 1 | 1 = write burst, 0 = read burst |
| cmdSize | input | 3 | Access size in bytes (1, 2, 4) |
| cmdCount | input | 16 | Number of words in the burst |
| cmdAddr | input | 32 | Byte address of the first word |
| shiftEn | input | 1 | Shift one bit on this clock |
| tdi | input | 1 | Serial bit from the host |
| tdo | output | 1 | Serial bit to the host |
| busy | output | 1 | Burst or bus access in progress |
| errFlag | output | 1 | Sticky bus-error flag |
| memReq | output | 1 | Bus access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Access byte address |
| memSize | output | 3 | Access size in bytes |
| memWdata | output | 32 | Right-aligned write data |
| memRdata | input | 32 | Right-aligned read data |
| memAck | input | 1 | Access completed normally |
| memErr | input | 1 | Access completed with an error |

## Verification
The assertions assume that the bus answers each request with exactly one cycle of `memAck` or `memErr`, and only while `memReq` is high. They also assume that a write word never finishes shifting in while the previous write access is still pending. The stimulus keeps within these limits in two ways. The memory responder acknowledges after a fixed latency of at most eight cycles and drops its strobe the following cycle. The host sequence also leaves twelve idle cycles after each write word before it shifts again.

// File: rtl/jbm_pkg.sv
package jbm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_DATA,
    ST_RD_CRC,
    ST_WR_DATA,
    ST_WR_CRC,
    ST_WR_MATCH
  } engState_t;

  typedef enum logic [1:0] {
    TDO_ZERO,
    TDO_READY,
    TDO_SHIFT,
    TDO_MATCH
  } tdoSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    crcInit;
    logic    crcStepOut;
    logic    crcStepIn;
    logic    srShiftOut;
    logic    srShiftIn;
    logic    srLoadCrc;
    logic    wrLatch;
    logic    addrLoad;
    logic    addrStep;
    logic    rdCapture;
    logic    readyBit;
    tdoSel_t tdoSel;
  } dpCtrl_t;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    return {1'b0, c[CRC_W-1:1]} ^ ((c[0] ^ b) ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/jbm_ctrl.sv
module jbm_ctrl
  import jbm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cmdValid,
  input  logic           cmdWrite,
  input  logic [2:0]     cmdSize,
  input  logic [CNT_W-1:0] cmdCount,
  input  logic           shiftEn,
  input  logic           memAck,
  input  logic           memErr,
  output logic           memReq,
  output logic           memWe,
  output logic           busy,
  output logic           errFlag,
  output logic [2:0]     sizeBytes,
  output dpCtrl_t        ctl
);

  localparam int BIT_W = $clog2(CRC_W) + 1;
  localparam logic [BIT_W-1:0] CRC_LAST = BIT_W'(CRC_W - 1);

  engState_t        state;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] wordsLeft;
  logic [2:0]       sizeReg;
  logic             reqR, weR, rdy, errR;

  logic [BIT_W-1:0] wordBits;
  logic             lastBit, lastWord, sizeOk, accept, done;

  assign wordBits = {sizeReg, 3'b000};
  assign lastBit  = (bitCnt == wordBits - BIT_W'(1));
  assign lastWord = (wordsLeft == CNT_W'(1));
  assign sizeOk   = (cmdSize == 3'd1) || (cmdSize == 3'd2) || (cmdSize == 3'd4);
  assign accept   = (state == ST_IDLE) && !reqR && cmdValid && sizeOk && (cmdCount != '0);
  assign done     = reqR && (memAck || memErr);

  assign memReq    = reqR;
  assign memWe     = weR;
  assign busy      = (state != ST_IDLE) || reqR;
  assign errFlag   = errR;
  assign sizeBytes = sizeReg;

  always_comb begin
    ctl          = '0;
    ctl.tdoSel   = TDO_ZERO;
    ctl.addrStep = done;
    ctl.readyBit = rdy;
    unique case (state)
      ST_IDLE: begin
        ctl.crcInit  = accept;
        ctl.addrLoad = accept;
      end
      ST_RD_WAIT: begin
        ctl.tdoSel    = TDO_READY;
        ctl.rdCapture = done;
      end
      ST_RD_DATA: begin
        ctl.tdoSel     = TDO_SHIFT;
        ctl.crcStepOut = shiftEn;
        ctl.srShiftOut = shiftEn;
        ctl.srLoadCrc  = shiftEn && lastBit && lastWord;
      end
      ST_RD_CRC: begin
        ctl.tdoSel     = TDO_SHIFT;
        ctl.srShiftOut = shiftEn;
      end
      ST_WR_DATA: begin
        ctl.srShiftIn = shiftEn;
        ctl.crcStepIn = shiftEn;
        ctl.wrLatch   = shiftEn && lastBit;
      end
      ST_WR_CRC:   ctl.srShiftIn = shiftEn;
      ST_WR_MATCH: ctl.tdoSel    = TDO_MATCH;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      wordsLeft <= '0;
      sizeReg   <= 3'd4;
      reqR      <= 1'b0;
      weR       <= 1'b0;
      rdy       <= 1'b0;
      errR      <= 1'b0;
    end else begin
      if (done) begin
        reqR <= 1'b0;
        if (memErr) errR <= 1'b1;
      end
      unique case (state)
        ST_IDLE: if (accept) begin
          sizeReg   <= cmdSize;
          wordsLeft <= cmdCount;
          bitCnt    <= '0;
          rdy       <= 1'b0;
          if (cmdWrite) begin
            state <= ST_WR_DATA;
          end else begin
            state <= ST_RD_WAIT;
            reqR  <= 1'b1;
            weR   <= 1'b0;
          end
        end
        ST_RD_WAIT: begin
          if (done) rdy <= 1'b1;
          if (shiftEn && rdy) begin
            state  <= ST_RD_DATA;
            bitCnt <= '0;
          end
        end
        ST_RD_DATA: if (shiftEn) begin
          if (lastBit) begin
            bitCnt    <= '0;
            wordsLeft <= wordsLeft - CNT_W'(1);
            if (lastWord) begin
              state <= ST_RD_CRC;
            end else begin
              state <= ST_RD_WAIT;
              rdy   <= 1'b0;
              reqR  <= 1'b1;
              weR   <= 1'b0;
            end
          end else begin
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        ST_RD_CRC: if (shiftEn) begin
          if (bitCnt == CRC_LAST) state <= ST_IDLE;
          else bitCnt <= bitCnt + BIT_W'(1);
        end
        ST_WR_DATA: if (shiftEn) begin
          if (lastBit) begin
            reqR      <= 1'b1;
            weR       <= 1'b1;
            bitCnt    <= '0;
            wordsLeft <= wordsLeft - CNT_W'(1);
            if (lastWord) state <= ST_WR_CRC;
          end else begin
            bitCnt <= bitCnt + BIT_W'(1);
          end
        end
        ST_WR_CRC: if (shiftEn) begin
          if (bitCnt == CRC_LAST) state <= ST_WR_MATCH;
          else bitCnt <= bitCnt + BIT_W'(1);
        end
        ST_WR_MATCH: if (shiftEn) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11: a pending request is held with the same direction until answered
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> (memReq && $stable(memWe)));

  // R1: a command arriving while busy leaves the burst setup untouched
  assert_busy_ignore_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> ($stable(sizeReg) && (state != ST_IDLE || !$past(state == ST_IDLE && !reqR))));

  // R4: data bits only move out once the status bit has reported ready
  assert_data_after_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_DATA) |-> rdy);

  // R7: the last bit of a write word launches a write access
  assert_write_launch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_DATA && shiftEn && lastBit) |=> (memReq && memWe));

  // R6: the CRC phase only follows the final word
  assert_crc_after_last_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RD_CRC) |-> (wordsLeft == '0));

endmodule

// File: rtl/jbm_datapath.sv
module jbm_datapath
  import jbm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic              tdi,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [2:0]        sizeBytes,
  input  logic [CRC_W-1:0]  memRdata,
  input  logic              memErr,
  output logic              tdo,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CRC_W-1:0]  memWdata
);

  logic [CRC_W-1:0]  dataSr, crc, wrBuf, srIn, aligned;
  logic [ADDR_W-1:0] addr;
  logic [CRC_W-1:0]  crcNextOut, crcNextIn;

  assign crcNextOut = crcStep(crc, dataSr[0]);
  assign crcNextIn  = crcStep(crc, tdi);
  assign srIn       = {tdi, dataSr[CRC_W-1:1]};

  always_comb begin
    unique case (sizeBytes)
      3'd1:    aligned = {24'b0, srIn[31:24]};
      3'd2:    aligned = {16'b0, srIn[31:16]};
      default: aligned = srIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataSr <= '0;
      crc    <= '1;
      wrBuf  <= '0;
      addr   <= '0;
    end else begin
      if (ctl.crcInit)         crc <= '1;
      else if (ctl.crcStepOut) crc <= crcNextOut;
      else if (ctl.crcStepIn)  crc <= crcNextIn;

      if (ctl.rdCapture)       dataSr <= memErr ? '0 : memRdata;
      else if (ctl.srLoadCrc)  dataSr <= crcNextOut;
      else if (ctl.srShiftOut) dataSr <= {1'b0, dataSr[CRC_W-1:1]};
      else if (ctl.srShiftIn)  dataSr <= srIn;

      if (ctl.wrLatch) wrBuf <= aligned;

      if (ctl.addrLoad)      addr <= cmdAddr;
      else if (ctl.addrStep) addr <= addr + ADDR_W'(sizeBytes);
    end
  end

  always_comb begin
    unique case (ctl.tdoSel)
      TDO_READY: tdo = ctl.readyBit;
      TDO_SHIFT: tdo = dataSr[0];
      TDO_MATCH: tdo = (dataSr == crc);
      default:   tdo = 1'b0;
    endcase
  end

  assign memAddr  = addr;
  assign memWdata = wrBuf;

  // R2: every burst begins from an all-ones accumulator
  assert_crc_preset_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.crcInit |=> (crc == '1));

  // R5: a completed access moves the address on by the access size
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrStep && !ctl.addrLoad) |=> (memAddr == $past(memAddr) + ADDR_W'($past(sizeBytes))));

endmodule

// File: rtl/jtag_burst_engine.sv
module jtag_burst_engine
  import jbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdWrite,
  input  logic [2:0]        cmdSize,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              shiftEn,
  input  logic              tdi,
  output logic              tdo,
  output logic              busy,
  output logic              errFlag,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        memSize,
  output logic [CRC_W-1:0]  memWdata,
  input  logic [CRC_W-1:0]  memRdata,
  input  logic              memAck,
  input  logic              memErr
);

  dpCtrl_t    ctl;
  logic [2:0] sizeBytes;

  jbm_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdValid(cmdValid), .cmdWrite(cmdWrite), .cmdSize(cmdSize), .cmdCount(cmdCount),
    .shiftEn(shiftEn), .memAck(memAck), .memErr(memErr),
    .memReq(memReq), .memWe(memWe), .busy(busy), .errFlag(errFlag),
    .sizeBytes(sizeBytes), .ctl(ctl)
  );

  jbm_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .tdi(tdi),
    .cmdAddr(cmdAddr), .sizeBytes(sizeBytes),
    .memRdata(memRdata), .memErr(memErr),
    .tdo(tdo), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memSize = sizeBytes;

  // R12: nothing is driven onto the serial output while idle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tdo);

  // R11: the address of a pending request does not move
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> $stable(memAddr));

  // R10: once raised the error flag stays up
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

// File: tb/sim_jtag_burst_engine.sv
module sim_jtag_burst_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdWrite = 1'b0;
  logic [2:0]  cmdSize = 3'd4;
  logic [15:0] cmdCount = 16'd0;
  logic [31:0] cmdAddr = 32'd0;
  logic        shiftEn = 1'b0, tdi = 1'b0;
  logic        tdo, busy, errFlag, memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [2:0]  memSize;
  logic [31:0] memRdata = 32'd0;
  logic        memAck = 1'b0, memErr = 1'b0;

  int checks = 0, failures = 0, cycles = 0, memLat = 3, waitCnt = 0;
  bit finished = 0;
  logic [7:0] mem [0:255];

  always #4 clk = ~clk;

  jtag_burst_engine u0 (.*);

  // behavioural bus responder: fixed latency, error above 0xF0
  always @(negedge clk) begin
    if (memAck || memErr) begin
      memAck <= 1'b0; memErr <= 1'b0; waitCnt = 0;
    end else if (memReq) begin
      waitCnt++;
      if (waitCnt >= memLat) begin
        waitCnt = 0;
        if (memAddr >= 32'hF0) begin
          memErr <= 1'b1; memRdata <= 32'hDEADBEEF;
        end else begin
          logic [31:0] w;
          w = 0;
          for (int k = 0; k < 4; k++) begin
            if (k < memSize) begin
              if (memWe) mem[memAddr[7:0]+8'(k)] = memWdata[8*k +: 8];
              w[8*k +: 8] = mem[memAddr[7:0]+8'(k)];
            end
          end
          memRdata <= w; memAck <= 1'b1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crcBit(input logic [31:0] c, input logic b);
    logic [31:0] r;
    r = c >> 1;
    if (c[0] ^ b) r = r ^ 32'hEDB88320;
    return r;
  endfunction

  task automatic shiftBit(input logic v, output logic o);
    @(negedge clk); shiftEn = 1'b1; tdi = v; #1 o = tdo;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); shiftEn = 1'b0; tdi = 1'b0; end
  endtask

  task automatic issueCmd(input bit wr, input logic [2:0] sz, input logic [15:0] cnt, input logic [31:0] a);
    @(negedge clk); shiftEn = 1'b0;
    cmdValid = 1'b1; cmdWrite = wr; cmdSize = sz; cmdCount = cnt; cmdAddr = a;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  task automatic readBurst(input logic [2:0] sz, input int cnt, input logic [31:0] a,
                           input int preWait, input int expectPolls, input bit intrude);
    logic [31:0] crc, got, exp;
    logic b;
    int polls;
    issueCmd(0, sz, 16'(cnt), a);
    if (intrude) begin
      @(negedge clk); cmdValid = 1'b1; cmdWrite = 1'b1; cmdSize = 3'd4; cmdCount = 16'd1; cmdAddr = 32'h40;
      @(negedge clk); cmdValid = 1'b0;
    end
    idle(preWait);
    crc = 32'hFFFFFFFF;
    for (int w = 0; w < cnt; w++) begin
      polls = 0;
      do begin shiftBit(1'b0, b); polls++; end while (!b && polls < 200);
      if (w == 0 && expectPolls == 1) check(polls == 1, "R3 first status ready", polls, 1);
      if (w == 0 && expectPolls > 1)  check(polls > 1, "R4 status not ready at first", polls, 2);
      exp = 0;
      for (int k = 0; k < sz; k++)
        exp[8*k +: 8] = (a + 32'(w*sz + k) >= 32'hF0) ? 8'h00 : mem[8'(a + 32'(w*sz + k))];
      got = 0;
      for (int i = 0; i < 8*sz; i++) begin
        shiftBit(1'b0, b); got[i] = b; crc = crcBit(crc, exp[i]);
      end
      check(got == exp, "R5/R10 read word", got, exp);
    end
    got = 0;
    for (int i = 0; i < 32; i++) begin shiftBit(1'b0, b); got[i] = b; end
    check(got == crc, "R2/R6 read CRC", got, crc);
  endtask

  task automatic writeBurst(input logic [2:0] sz, input int cnt, input logic [31:0] a,
                            input logic [31:0] seed, input bit corrupt);
    logic [31:0] crc, d, hostCrc;
    logic b;
    crc = 32'hFFFFFFFF;
    issueCmd(1, sz, 16'(cnt), a);
    for (int w = 0; w < cnt; w++) begin
      d = seed + 32'(w) * 32'h01030507;
      for (int i = 0; i < 8*sz; i++) begin shiftBit(d[i], b); crc = crcBit(crc, d[i]); end
      idle(12);
    end
    hostCrc = corrupt ? (crc ^ 32'h10) : crc;
    for (int i = 0; i < 32; i++) shiftBit(hostCrc[i], b);
    shiftBit(1'b0, b);
    check(b == !corrupt, "R8 CRC match bit", 32'(b), 32'(!corrupt));
    idle(12);
    for (int w = 0; w < cnt; w++) begin
      logic [31:0] got;
      d = seed + 32'(w) * 32'h01030507;
      got = 0;
      for (int k = 0; k < sz; k++) got[8*k +: 8] = mem[8'(a + 32'(w*sz + k))];
      if (sz < 4) d = d & ((32'h1 << (8*sz)) - 1);
      check(got == d, "R7/R5 written word", got, d);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    check(!busy && !memReq && !errFlag && !tdo, "R12 reset state", {busy, memReq, errFlag, tdo}, 0);
    rstN = 1'b1;
    idle(2);
    // R3: fast bus, host waits, first status bit already ready
    memLat = 3;
    readBurst(3'd4, 3, 32'h10, 10, 1, 0);
    // R9: next command given on the very next clock
    readBurst(3'd2, 4, 32'h22, 0, 0, 0);
    @(negedge clk); #1;
    check(!busy && !tdo, "R9/R12 idle after burst", {busy, tdo}, 0);
    // R4: slow bus, immediate polling sees not-ready bits
    memLat = 8;
    readBurst(3'd1, 5, 32'h31, 0, 2, 0);
    // R1: invalid size and zero count are ignored
    issueCmd(0, 3'd3, 16'd2, 32'h0);
    #1 check(!busy && !memReq, "R1 bad size ignored", {busy, memReq}, 0);
    issueCmd(0, 3'd4, 16'd0, 32'h0);
    #1 check(!busy && !memReq, "R1 zero count ignored", {busy, memReq}, 0);
    // R1: a write command during a read burst is ignored
    memLat = 2;
    readBurst(3'd4, 2, 32'h50, 0, 0, 1);
    idle(4);
    check(!busy, "R1 no burst after intruder", busy, 0);
    // writes: R7, R8
    writeBurst(3'd4, 3, 32'h80, 32'hA1B2C3D4, 0);
    writeBurst(3'd1, 4, 32'h91, 32'h0000005A, 0);
    writeBurst(3'd2, 2, 32'hA2, 32'h00001234, 1);
    readBurst(3'd4, 3, 32'h80, 0, 0, 0);
    check(!errFlag, "R10 no error yet", errFlag, 0);
    // R10: bus error on reads
    readBurst(3'd4, 2, 32'hEC, 0, 0, 0);
    idle(2);
    check(errFlag, "R10 sticky error", errFlag, 1);
    readBurst(3'd2, 1, 32'h04, 0, 0, 0);
    check(errFlag, "R10 error stays set", errFlag, 1);
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        finished = 1;
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

endmodule